// File: doc/BRIEF.md
# Ignition Pulse Shaper

This block turns a raw ignition trigger into a train of clean, fixed-length output pulses. Each accepted rising edge of the trigger produces exactly one output pulse. The pulse begins after a short, bounded hold-off and lasts a fixed time, however long the trigger stays high.

The trigger is first brought into the clock domain through a chain of flip-flops. A rising edge starts a qualification window. The trigger must remain high for the whole window, or the event is thrown away as noise. After the window the output goes high for a counted number of cycles.

The block cannot be retriggered while a pulse is running. The one exception is an edge that lands in the final cycle of a pulse. That edge is taken at once, so a fast trigger loses no more edges than the pulse length forces it to. The hold-off and width are given in nanoseconds, together with the clock frequency, and the block turns them into cycle counts when it is elaborated.

Top module: `ign_pulse_shaper`

## Requirements
- R1: During reset and after it, `pulse_o` is low. A reset that arrives during a pulse ends that pulse. No pulse follows until a new rising edge is seen after reset.
- R2: The hold-off count is CLK_HZ·DELAY_NS/1e9 cycles, which is 47 cycles at the defaults. For an accepted edge, `pulse_o` rises exactly SYNC_STAGES+hold-off+1 clock edges after the first edge that samples `ign_in` high. At the defaults that is 50 cycles of 1 µs, which lies inside the 31.3 µs to 63.2 µs window.
- R3: Each output pulse lasts exactly CLK_HZ·WIDTH_NS/1e9 cycles, which is 2500 cycles (2.5 ms) at the defaults. The width is the same whether the trigger is short or stays high longer than the pulse.
- R4: A pulse is issued only if `ign_in` is sampled high on hold-off+1 consecutive clock edges, which is 48 edges at the defaults. A trigger that is high for 47 edges or fewer produces no pulse.
- R5: While the output is high, rising edges of the trigger are ignored, except for an edge that arrives in the final cycle of the pulse. An edge whose detection falls one cycle before that final cycle produces no further pulse.
- R6: A rising edge whose detection falls in the final cycle of a pulse starts a new qualification immediately. The next pulse then follows with the same latency as in R2.
- R7: Each trigger rising edge gives at most one pulse, and a trigger held at a constant level gives no more pulses. Over a sequence of varied trigger high and low times, the number of pulses equals the number of rising edges that qualify under R4 and R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, nominally 1 MHz |
| rst | input | 1 | Synchronous reset, active high |
| ign_in | input | 1 | Raw, asynchronous ignition trigger |
| pulse_o | output | 1 | Shaped fixed-width output pulse |

## Verification
The end of a running pulse and the acceptance of a new trigger edge can fall in the same clock cycle. This is the cycle where the width counter expires and the edge detector fires. The bench provokes the collision by raising the trigger exactly hold-off+width cycles after the previous raise. It then expects a second pulse at the normal latency. A companion case raises the trigger one cycle earlier and expects the edge to be swallowed, with no second pulse. The checker adds a property that a collision in that cycle leaves the block qualifying with the output low.

// File: rtl/ign_shaper_pkg.sv
package ign_shaper_pkg;

  typedef enum logic [1:0] {
    SHP_IDLE  = 2'd0,
    SHP_QUAL  = 2'd1,
    SHP_PULSE = 2'd2
  } shp_state_e;

  // Convert a duration in nanoseconds to whole clock cycles.
  function automatic int unsigned ns_to_cycles(longint unsigned clk_hz,
                                               longint unsigned dur_ns);
    longint unsigned prod;
    prod = clk_hz * dur_ns;
    return 32'(prod / 64'd1_000_000_000);
  endfunction

  // Counter width able to hold the larger of two terminal counts.
  function automatic int unsigned span_bits(int unsigned a, int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m);
  endfunction

endpackage

// File: rtl/ign_sync.sv
module ign_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ign_edge.sv
module ign_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/ign_seq.sv
module ign_seq
  import ign_shaper_pkg::*;
#(
  parameter int unsigned DELAY_CYC = 47,
  parameter int unsigned WIDTH_CYC = 2500
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic rise,
  output logic pulse_o,
  output logic evt_accept,
  output logic evt_glitch,
  output logic evt_fire,
  output logic evt_done,
  output logic in_qual
);
  localparam int unsigned CW = span_bits(DELAY_CYC, WIDTH_CYC);
  localparam logic [CW-1:0] DLY_LAST = CW'(DELAY_CYC - 1);
  localparam logic [CW-1:0] WID_LAST = CW'(WIDTH_CYC - 1);

  shp_state_e    state, state_nxt;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          pulse_q;
  logic          dly_end, wid_end, in_pulse;

  assign in_qual  = (state == SHP_QUAL);
  assign in_pulse = (state == SHP_PULSE);
  assign dly_end  = in_qual  && (cnt == DLY_LAST);
  assign wid_end  = in_pulse && (cnt == WID_LAST);

  // Named events for the checker.
  assign evt_glitch = in_qual && !lvl;
  assign evt_fire   = in_qual && lvl && dly_end;
  assign evt_done   = wid_end;
  assign evt_accept = rise && ((state == SHP_IDLE) || wid_end);

  always_comb begin
    state_nxt = state;
    cnt_nxt   = cnt;
    unique case (state)
      SHP_IDLE: begin
        if (rise) begin
          state_nxt = SHP_QUAL;
          cnt_nxt   = '0;
        end
      end
      SHP_QUAL: begin
        if (!lvl) begin
          state_nxt = SHP_IDLE;
        end else if (dly_end) begin
          state_nxt = SHP_PULSE;
          cnt_nxt   = '0;
        end else begin
          cnt_nxt = cnt + 1'b1;
        end
      end
      SHP_PULSE: begin
        if (wid_end) begin
          cnt_nxt   = '0;
          state_nxt = rise ? SHP_QUAL : SHP_IDLE;
        end else begin
          cnt_nxt = cnt + 1'b1;
        end
      end
      default: state_nxt = SHP_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SHP_IDLE;
      cnt     <= '0;
      pulse_q <= 1'b0;
    end else begin
      state   <= state_nxt;
      cnt     <= cnt_nxt;
      pulse_q <= (state_nxt == SHP_PULSE);
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/ign_pulse_shaper.sv
module ign_pulse_shaper
  import ign_shaper_pkg::*;
#(
  parameter longint unsigned CLK_HZ      = 1_000_000,
  parameter longint unsigned DELAY_NS    = 47_000,
  parameter longint unsigned WIDTH_NS    = 2_500_000,
  parameter int unsigned     SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ign_in,
  output logic pulse_o
);
  localparam int unsigned DELAY_CYC = ns_to_cycles(CLK_HZ, DELAY_NS);
  localparam int unsigned WIDTH_CYC = ns_to_cycles(CLK_HZ, WIDTH_NS);

  logic ign_lvl;
  logic evt_rise;
  logic evt_accept, evt_glitch, evt_fire, evt_done, in_qual;

  ign_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (ign_in),
    .q   (ign_lvl)
  );

  ign_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (ign_lvl),
    .rise (evt_rise)
  );

  ign_seq #(
    .DELAY_CYC (DELAY_CYC),
    .WIDTH_CYC (WIDTH_CYC)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .lvl        (ign_lvl),
    .rise       (evt_rise),
    .pulse_o    (pulse_o),
    .evt_accept (evt_accept),
    .evt_glitch (evt_glitch),
    .evt_fire   (evt_fire),
    .evt_done   (evt_done),
    .in_qual    (in_qual)
  );
endmodule

// File: rtl/ign_pulse_shaper_chk.sv
module ign_pulse_shaper_chk #(
  parameter int unsigned DELAY_CYC = 47,
  parameter int unsigned WIDTH_CYC = 2500
) (
  input logic clk,
  input logic rst,
  input logic pulse_o,
  input logic evt_rise,
  input logic evt_accept,
  input logic evt_glitch,
  input logic evt_fire,
  input logic evt_done,
  input logic in_qual
);
  int unsigned hi_cnt;
  int unsigned gap_cnt;
  logic        rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      hi_cnt  <= 0;
      gap_cnt <= 0;
    end else begin
      hi_cnt  <= pulse_o ? hi_cnt + 1 : 0;
      if (evt_accept)           gap_cnt <= 0;
      else if (gap_cnt < 32'hFFFF) gap_cnt <= gap_cnt + 1;
    end
  end

  // R1
  always_ff @(posedge clk) begin
    if (rst_q) reset_low_chk: assert (!pulse_o);
  end

  // R2
  hold_off_len_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_o) |-> (gap_cnt == DELAY_CYC));

  // R3
  width_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pulse_o) |-> (hi_cnt == WIDTH_CYC));

  // R4
  glitch_drop_chk: assert property (@(posedge clk) disable iff (rst)
    evt_glitch |=> !pulse_o && !in_qual);

  // R5
  no_retrigger_chk: assert property (@(posedge clk) disable iff (rst)
    (pulse_o && evt_rise && !evt_done) |=> pulse_o);

  // R6
  tail_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_done && evt_rise) |=> (in_qual && !pulse_o));

  // R7
  fire_once_chk: assert property (@(posedge clk) disable iff (rst)
    evt_fire |=> $rose(pulse_o));
endmodule

bind ign_pulse_shaper ign_pulse_shaper_chk #(
  .DELAY_CYC (DELAY_CYC),
  .WIDTH_CYC (WIDTH_CYC)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pulse_o    (pulse_o),
  .evt_rise   (evt_rise),
  .evt_accept (evt_accept),
  .evt_glitch (evt_glitch),
  .evt_fire   (evt_fire),
  .evt_done   (evt_done),
  .in_qual    (in_qual)
);

// File: tb/ign_pulse_shaper_test.sv
`timescale 1ns/1ps
module ign_pulse_shaper_test;
  localparam int CLK_NS = 1000;
  localparam int SYNC   = 2;
  localparam int DLY    = 47_000 / CLK_NS;
  localparam int WID    = 2_500_000 / CLK_NS;
  localparam int LAT    = SYNC + DLY + 1;
  localparam int NV     = 6;
  // {trigger high cycles, trigger low cycles, pulses expected}
  localparam int VEC [NV][3] = '{
    '{100,  3000, 1},
    '{DLY,  200,  0},
    '{DLY+1, 3000, 1},
    '{3000, 100,  1},
    '{1,    100,  0},
    '{600,  2900, 1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ign = 1'b0;
  logic pulse;

  int     checks = 0;
  int     fails  = 0;
  longint cyc = 0;
  longint rise_cyc = 0;
  longint p_start = 0;
  longint last_lat = -1;
  longint last_wid = -1;
  int     npulse = 0;
  logic   prev_p = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  ign_pulse_shaper uut (
    .clk     (clk),
    .rst     (rst),
    .ign_in  (ign),
    .pulse_o (pulse)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (pulse && !prev_p) begin
      npulse++;
      last_lat = cyc - rise_cyc;
      p_start  = cyc;
    end
    if (!pulse && prev_p) last_wid = cyc - p_start;
    prev_p = pulse;
  end

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic raise();
    ign = 1'b1;
    rise_cyc = cyc;
  endtask

  initial begin
    #(CLK_NS * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int n0;
    wait_n(5);
    check("R1 output low in reset", longint'(pulse), 0);
    rst = 1'b0;
    wait_n(100);
    check("R1 no pulse after reset", npulse, 0);

    for (int i = 0; i < NV; i++) begin
      n0 = npulse;
      last_lat = -1;
      last_wid = -1;
      raise();
      wait_n(VEC[i][0]);
      ign = 1'b0;
      wait_n(VEC[i][1]);
      if (VEC[i][0] <= DLY) check("R4 short trigger dropped", npulse - n0, VEC[i][2]);
      else                  check("R7 one pulse per edge", npulse - n0, VEC[i][2]);
      if (VEC[i][2] == 1) begin
        check("R2 latency", last_lat, LAT);
        check("R3 width", last_wid, WID);
      end
    end

    // R5: second edge well inside the pulse is ignored
    n0 = npulse;
    raise(); wait_n(100); ign = 1'b0; wait_n(1300);
    raise(); wait_n(100); ign = 1'b0; wait_n(3000);
    check("R5 mid-pulse edge ignored", npulse - n0, 1);
    check("R3 width after ignored edge", last_wid, WID);

    // R5: edge detected one cycle before the last pulse cycle is ignored
    n0 = npulse;
    raise(); wait_n(100); ign = 1'b0; wait_n(DLY + WID - 101);
    raise(); wait_n(3000); ign = 1'b0; wait_n(100);
    check("R5 edge before final cycle ignored", npulse - n0, 1);

    // R6: edge detected in the final pulse cycle is accepted
    n0 = npulse;
    raise(); wait_n(100); ign = 1'b0; wait_n(DLY + WID - 100);
    raise(); wait_n(100); ign = 1'b0; wait_n(3000);
    check("R6 final-cycle edge accepted", npulse - n0, 2);
    check("R6 latency of second pulse", last_lat, LAT);
    check("R6 width of second pulse", last_wid, WID);

    // R1: reset during a pulse
    n0 = npulse;
    raise(); wait_n(600);
    check("R1 pulse running before reset", longint'(pulse), 1);
    rst = 1'b1; ign = 1'b0;
    wait_n(3);
    check("R1 reset ends pulse", longint'(pulse), 0);
    rst = 1'b0;
    wait_n(3000);
    check("R1 no pulse after mid-pulse reset", npulse - n0, 1);
    check("R1 output stays low", longint'(pulse), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule